// File: doc/BRIEF.md
# Supernode Address Cache for Prefix Lookup

This block keeps recently used routing-tree pointers close to a lookup engine. The routing tree is stored in memory as supernodes: each one covers four binary levels, and supernodes start at every fourth level, so a 32-level tree becomes eight supernode levels. The cache holds the memory addresses of supernodes that belong to 16-bit and 24-bit prefixes. Given a 32-bit destination, it answers in one cycle with the address of the deepest cached supernode. The engine then starts its walk from that supernode instead of from the root.

The cache is set associative, with four ways by default. The top twelve address bits choose the set. With the default of 64 sets, the low six of those twelve bits form the index and the upper six become part of the tag. A single set can hold entries of both prefix lengths. Their tags have different widths, and when both lengths match, the longer prefix is returned. After a miss, the engine installs the supernode it found through the fill port. Replacement is least recently used. An asynchronous flush input empties the whole cache.

Top module: `snode_cache`

## Requirements
- R1: The set is selected by address bits [20+SETS_LOG2-1:20]. Address bits [31:20+SETS_LOG2] are stored as an upper tag, so two addresses that differ only in those bits never hit each other's entries.
- R2: A 24-bit entry (fill_len24=1) hits a lookup whose bits [31:8] equal those of the filled address. A hit returns rsp_len24=1 and the stored node address.
- R3: A 16-bit entry (fill_len24=0) hits a lookup whose bits [31:16] equal those of the filled address, regardless of bits [15:0]. A hit returns rsp_len24=0.
- R4: When a 24-bit entry and a 16-bit entry both match, the response carries the 24-bit entry's length flag and node address.
- R5: On a miss, rsp_hit, rsp_len24 and rsp_node are all zero.
- R6: rsp_valid is high in the cycle after a cycle with req_valid high, and low after a cycle without a request. The response is registered.
- R7: A fill into a set whose ways are all valid replaces the way least recently used. Both lookup hits and fills count as use.
- R8: A fill uses an invalid way of its set before it evicts any valid entry.
- R9: A fill whose upper tag, compared tag bits and length match a valid entry overwrites that entry's node address and does not take another way.
- R10: Raising flush, with no clock needed, invalidates every entry, so the next lookups miss.
- R11: While rst_n is low, the response outputs are zero and all entries are invalid.
- R12: A lookup in the same cycle as a fill sees the contents as they were before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Asynchronous invalidate of all entries and LRU state, active high |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Destination address to look up |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | A cached supernode was found |
| rsp_len24 | output | 1 | 1: the hit is for a 24-bit prefix, 0: for a 16-bit prefix |
| rsp_node | output | NODE_W | Memory address of the supernode |
| fill_valid | input | 1 | Install strobe |
| fill_addr | input | 32 | Address whose prefix is installed |
| fill_len24 | input | 1 | 1: install a 24-bit entry, 0: install a 16-bit entry |
| fill_node | input | NODE_W | Supernode memory address to store |

## Verification
The lookups cover several cases: an address covered by only the short entry, by only the long entry, and by both. This separates the length-priority logic from plain tag matching. Addresses that differ only in bits [19:16], or only in the upper tag bits, check that each tag slice is compared. A set is filled to capacity in a chosen touch order, so that exactly one particular way must be evicted. A fill with the same tag and length, and a fill issued together with a lookup, separate overwrite from allocation and old contents from new ones.

// File: rtl/snode_pkg.sv
package snode_pkg;
   localparam int ADDR_W  = 32;
   localparam int TOP_W   = 12;
   localparam int SET_LSB = 20;
   localparam int TAG_LSB = 8;
   localparam int TAG_W   = 12;
   localparam int T16_W   = 4;
endpackage

// File: rtl/snode_match.sv
module snode_match #(
   parameter int WAYS = 4,
   parameter int HI_W = 6
) (
   input  logic [WAYS-1:0]            valid,
   input  logic [WAYS-1:0]            is24,
   input  logic [WAYS-1:0][HI_W-1:0]  tag_hi,
   input  logic [WAYS-1:0][11:0]      tag_lo,
   input  logic [HI_W-1:0]            key_hi,
   input  logic [11:0]                key_lo,
   output logic [WAYS-1:0]            m24,
   output logic [WAYS-1:0]            m16
);
   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic hi_eq;
      assign hi_eq  = valid[w] && (tag_hi[w] == key_hi);
      assign m24[w] = hi_eq && is24[w] && (tag_lo[w] == key_lo);
      assign m16[w] = hi_eq && !is24[w] && (tag_lo[w][11:8] == key_lo[11:8]);
   end
endmodule

// File: rtl/snode_penc.sv
module snode_penc #(
   parameter int WAYS  = 4,
   parameter int WAY_W = 2
) (
   input  logic [WAYS-1:0]  vec,
   output logic             any,
   output logic [WAY_W-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = WAYS - 1; i >= 0; i--) begin
         if (vec[i]) idx = i[WAY_W-1:0];
      end
   end
   assign any = |vec;
endmodule

// File: rtl/snode_lru.sv
module snode_lru #(
   parameter int WAYS  = 4,
   parameter int WAY_W = 2
) (
   input  logic [WAYS-1:0][WAY_W-1:0] ages_in,
   input  logic [WAYS-1:0]            valid_in,
   input  logic [WAY_W-1:0]           touch,
   output logic [WAYS-1:0][WAY_W-1:0] ages_out,
   output logic [WAY_W-1:0]           victim
);
   localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

   for (genvar w = 0; w < WAYS; w++) begin : g_age
      always_comb begin
         if (touch == WAY_W'(w))
            ages_out[w] = '0;
         else if (ages_in[w] < ages_in[touch])
            ages_out[w] = ages_in[w] + 1'b1;
         else
            ages_out[w] = ages_in[w];
      end
   end

   always_comb begin
      logic found;
      found  = 1'b0;
      victim = '0;
      for (int i = 0; i < WAYS; i++) begin
         if (!found && !valid_in[i]) begin
            victim = i[WAY_W-1:0];
            found  = 1'b1;
         end
      end
      for (int i = 0; i < WAYS; i++) begin
         if (!found && ages_in[i] == OLDEST) begin
            victim = i[WAY_W-1:0];
            found  = 1'b1;
         end
      end
   end
endmodule

// File: rtl/snode_cache.sv
module snode_cache
   import snode_pkg::*;
#(
   parameter int NODE_W    = 20,
   parameter int WAYS      = 4,
   parameter int SETS_LOG2 = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              req_valid,
   input  logic [31:0]       req_addr,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_len24,
   output logic [NODE_W-1:0] rsp_node,
   input  logic              fill_valid,
   input  logic [31:0]       fill_addr,
   input  logic              fill_len24,
   input  logic [NODE_W-1:0] fill_node
);
   localparam int SETS  = 1 << SETS_LOG2;
   localparam int HI_W  = TOP_W - SETS_LOG2;
   localparam int WAY_W = $clog2(WAYS);

   if (SETS_LOG2 < 1 || SETS_LOG2 >= TOP_W) begin : g_bad_sets
      $error("SETS_LOG2 must lie in 1..11");
   end
   if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (NODE_W < 1) begin : g_bad_node
      $error("NODE_W must be positive");
   end

   // storage
   logic [WAYS-1:0]             v_q    [SETS];
   logic [WAYS-1:0]             l24_q  [SETS];
   logic [WAYS-1:0][WAY_W-1:0]  age_q  [SETS];
   logic [WAYS-1:0][HI_W-1:0]   thi_q  [SETS];
   logic [WAYS-1:0][11:0]       tlo_q  [SETS];
   logic [NODE_W-1:0]           node_q [SETS][WAYS];

   // key slices
   logic [SETS_LOG2-1:0] r_set, f_set;
   logic [HI_W-1:0]      r_hi, f_hi;
   logic [11:0]          r_lo, f_lo, f_lo_st;

   assign r_set   = req_addr[SET_LSB +: SETS_LOG2];
   assign f_set   = fill_addr[SET_LSB +: SETS_LOG2];
   assign r_hi    = req_addr[ADDR_W-1 -: HI_W];
   assign f_hi    = fill_addr[ADDR_W-1 -: HI_W];
   assign r_lo    = req_addr[TAG_LSB +: TAG_W];
   assign f_lo    = fill_addr[TAG_LSB +: TAG_W];
   assign f_lo_st = fill_len24 ? f_lo : {f_lo[11:8], 8'h00};

   // lookup path
   logic [WAYS-1:0]  r_m24, r_m16;
   logic             r_any24, r_any16, r_hit;
   logic [WAY_W-1:0] r_w24, r_w16, r_way;

   snode_match #(.WAYS(WAYS), .HI_W(HI_W)) u_rmatch (
      .valid(v_q[r_set]), .is24(l24_q[r_set]),
      .tag_hi(thi_q[r_set]), .tag_lo(tlo_q[r_set]),
      .key_hi(r_hi), .key_lo(r_lo), .m24(r_m24), .m16(r_m16));

   snode_penc #(.WAYS(WAYS), .WAY_W(WAY_W)) u_rp24 (.vec(r_m24), .any(r_any24), .idx(r_w24));
   snode_penc #(.WAYS(WAYS), .WAY_W(WAY_W)) u_rp16 (.vec(r_m16), .any(r_any16), .idx(r_w16));

   assign r_hit = r_any24 | r_any16;
   assign r_way = r_any24 ? r_w24 : r_w16;

   // fill path
   logic [WAYS-1:0]  f_m24, f_m16, f_same;
   logic             f_any;
   logic [WAY_W-1:0] f_way, f_victim, f_tgt;
   logic [WAYS-1:0][WAY_W-1:0] f_ages, r_ages;
   logic [WAY_W-1:0] r_vic_unused;

   snode_match #(.WAYS(WAYS), .HI_W(HI_W)) u_fmatch (
      .valid(v_q[f_set]), .is24(l24_q[f_set]),
      .tag_hi(thi_q[f_set]), .tag_lo(tlo_q[f_set]),
      .key_hi(f_hi), .key_lo(f_lo), .m24(f_m24), .m16(f_m16));

   assign f_same = fill_len24 ? f_m24 : f_m16;

   snode_penc #(.WAYS(WAYS), .WAY_W(WAY_W)) u_fpe (.vec(f_same), .any(f_any), .idx(f_way));

   snode_lru #(.WAYS(WAYS), .WAY_W(WAY_W)) u_flru (
      .ages_in(age_q[f_set]), .valid_in(v_q[f_set]), .touch(f_tgt),
      .ages_out(f_ages), .victim(f_victim));

   assign f_tgt = f_any ? f_way : f_victim;

   snode_lru #(.WAYS(WAYS), .WAY_W(WAY_W)) u_rlru (
      .ages_in(age_q[r_set]), .valid_in(v_q[r_set]), .touch(r_way),
      .ages_out(r_ages), .victim(r_vic_unused));

   // valid bits and ages: cleared by reset or flush
   always_ff @(posedge clk or negedge rst_n or posedge flush) begin
      if (!rst_n || flush) begin
         for (int s = 0; s < SETS; s++) begin
            v_q[s]   <= '0;
            l24_q[s] <= '0;
            for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
         end
      end else if (fill_valid) begin
         v_q[f_set][f_tgt]   <= 1'b1;
         l24_q[f_set][f_tgt] <= fill_len24;
         age_q[f_set]        <= f_ages;
      end else if (req_valid && r_hit) begin
         age_q[r_set] <= r_ages;
      end
   end

   // tags and node addresses: no reset needed
   always_ff @(posedge clk) begin
      if (fill_valid) begin
         thi_q[f_set][f_tgt]  <= f_hi;
         tlo_q[f_set][f_tgt]  <= f_lo_st;
         node_q[f_set][f_tgt] <= fill_node;
      end
   end

   // registered response
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_len24 <= 1'b0;
         rsp_node  <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_hit   <= req_valid && r_hit;
         rsp_len24 <= req_valid && r_any24;
         rsp_node  <= (req_valid && r_hit) ? node_q[r_set][r_way] : '0;
      end
   end
endmodule

// File: rtl/snode_cache_chk.sv
module snode_cache_chk #(
   parameter int NODE_W = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flush,
   input logic              req_valid,
   input logic [31:0]       req_addr,
   input logic              rsp_valid,
   input logic              rsp_hit,
   input logic              rsp_len24,
   input logic [NODE_W-1:0] rsp_node,
   input logic              fill_valid,
   input logic [31:0]       fill_addr
);
   logic        pf_v;
   logic [31:0] pf_addr;

   always_ff @(posedge clk or negedge rst_n or posedge flush) begin
      if (!rst_n || flush) begin
         pf_v    <= 1'b0;
         pf_addr <= '0;
      end else begin
         pf_v    <= fill_valid;
         pf_addr <= fill_addr;
      end
   end

   a_r6_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r6_no_rsp_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   a_r5_miss_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (!rsp_len24 && rsp_node == '0));
   a_r6_hit_only_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> rsp_valid);
   a_r10_flush_forces_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && flush) |=> !rsp_hit);
   a_r2_fill_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && pf_v && !flush && req_addr == pf_addr) |=> rsp_hit);
   a_r11_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> (!rsp_valid && !rsp_hit));
endmodule

bind snode_cache snode_cache_chk #(.NODE_W(NODE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .flush(flush),
   .req_valid(req_valid), .req_addr(req_addr),
   .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_len24(rsp_len24),
   .rsp_node(rsp_node), .fill_valid(fill_valid), .fill_addr(fill_addr));

// File: tb/sim_snode_cache.sv
module sim_snode_cache;
   localparam int NW = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flush = 1'b0;
   logic          req_valid = 1'b0;
   logic [31:0]   req_addr = '0;
   logic          rsp_valid, rsp_hit, rsp_len24;
   logic [NW-1:0] rsp_node;
   logic          fill_valid = 1'b0;
   logic [31:0]   fill_addr = '0;
   logic          fill_len24 = 1'b0;
   logic [NW-1:0] fill_node = '0;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   snode_cache #(.NODE_W(NW)) u0 (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .req_valid(req_valid), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_len24(rsp_len24),
      .rsp_node(rsp_node), .fill_valid(fill_valid), .fill_addr(fill_addr),
      .fill_len24(fill_len24), .fill_node(fill_node));

   // {fill, len24, addr, node, exp_hit, exp_len24, exp_node}
   localparam logic [75:0] VEC [10] = '{
      {1'b0, 1'b0, 32'h0A1B2C00, 20'h0,     1'b0, 1'b0, 20'h0},     // R11 empty after reset
      {1'b1, 1'b0, 32'h0A1B0000, 20'h11111, 1'b0, 1'b0, 20'h0},     // 16-bit fill
      {1'b0, 1'b0, 32'h0A1B2C44, 20'h0,     1'b1, 1'b0, 20'h11111}, // R3
      {1'b1, 1'b1, 32'h0A1B2C00, 20'h22222, 1'b0, 1'b0, 20'h0},     // 24-bit fill
      {1'b0, 1'b0, 32'h0A1B2CFF, 20'h0,     1'b1, 1'b1, 20'h22222}, // R4 / R2
      {1'b0, 1'b0, 32'h0A1B3000, 20'h0,     1'b1, 1'b0, 20'h11111}, // R3 short only
      {1'b0, 1'b0, 32'h0A1C2C00, 20'h0,     1'b0, 1'b0, 20'h0},     // R3 bits 19:16 differ
      {1'b0, 1'b0, 32'h4A1B2C00, 20'h0,     1'b0, 1'b0, 20'h0},     // R1 upper tag differs
      {1'b1, 1'b0, 32'h0A1BFFFF, 20'h33333, 1'b0, 1'b0, 20'h0},     // R9 overwrite
      {1'b0, 1'b0, 32'h0A1B5555, 20'h0,     1'b1, 1'b0, 20'h33333}  // R9
   };

   task automatic check_rsp(input string rq, input logic eh, input logic el,
                            input logic [NW-1:0] en);
      checks++;
      if (rsp_valid !== 1'b1 || rsp_hit !== eh || rsp_len24 !== el || rsp_node !== en) begin
         errors++;
         $display("FAIL %s: got v=%0b hit=%0b len24=%0b node=%h, expected v=1 hit=%0b len24=%0b node=%h",
                  rq, rsp_valid, rsp_hit, rsp_len24, rsp_node, eh, el, en);
      end
   endtask

   task automatic lookup(input string rq, input logic [31:0] a, input logic eh,
                         input logic el, input logic [NW-1:0] en);
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = a;
      @(negedge clk);
      req_valid = 1'b0;
      check_rsp(rq, eh, el, en);
   endtask

   task automatic fill(input logic [31:0] a, input logic l, input logic [NW-1:0] n);
      @(negedge clk);
      fill_valid = 1'b1;
      fill_addr  = a;
      fill_len24 = l;
      fill_node  = n;
      @(negedge clk);
      fill_valid = 1'b0;
      checks++;
      if (rsp_valid !== 1'b0) begin   // R6 no response without request
         errors++;
         $display("FAIL R6: rsp_valid=%0b after idle cycle, expected 0", rsp_valid);
      end
   endtask

   task automatic pulse_flush();
      @(negedge clk);
      #0.5 flush = 1'b1;
      #0.5 flush = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_node !== '0) begin
         errors++;
         $display("FAIL R11: reset outputs v=%0b hit=%0b node=%h, expected all zero",
                  rsp_valid, rsp_hit, rsp_node);
      end
      rst_n = 1'b1;

      for (int i = 0; i < 10; i++) begin
         if (VEC[i][75])
            fill(VEC[i][73:42], VEC[i][74], VEC[i][41:22]);
         else
            lookup($sformatf("R2/R3/R4 vector %0d", i), VEC[i][73:42],
                   VEC[i][21], VEC[i][20], VEC[i][19:0]);
      end

      // R10 flush between clock edges
      pulse_flush();
      lookup("R10 long entry gone", 32'h0A1B2C00, 1'b0, 1'b0, '0);
      lookup("R10 short entry gone", 32'h0A1B5555, 1'b0, 1'b0, '0);

      // R8 / R7: four 24-bit fills into one set, then a fifth
      fill(32'h0A100100, 1'b1, 20'h00001);
      fill(32'h0A100200, 1'b1, 20'h00002);
      fill(32'h0A100300, 1'b1, 20'h00003);
      fill(32'h0A100400, 1'b1, 20'h00004);
      lookup("R8 way kept 2", 32'h0A100200, 1'b1, 1'b1, 20'h00002);
      lookup("R8 way kept 3", 32'h0A100300, 1'b1, 1'b1, 20'h00003);
      lookup("R8 way kept 4", 32'h0A100400, 1'b1, 1'b1, 20'h00004);
      lookup("R8 way kept 1", 32'h0A100100, 1'b1, 1'b1, 20'h00001);
      fill(32'h0A100500, 1'b1, 20'h00005);
      lookup("R7 LRU evicted", 32'h0A100200, 1'b0, 1'b0, '0);
      lookup("R7 recent kept", 32'h0A100100, 1'b1, 1'b1, 20'h00001);
      lookup("R7 new entry", 32'h0A100500, 1'b1, 1'b1, 20'h00005);
      lookup("R7 other kept", 32'h0A100300, 1'b1, 1'b1, 20'h00003);

      // R12 fill and lookup in the same cycle
      pulse_flush();
      @(negedge clk);
      fill_valid = 1'b1;
      fill_addr  = 32'h77770000;
      fill_len24 = 1'b0;
      fill_node  = 20'hABCDE;
      req_valid  = 1'b1;
      req_addr   = 32'h77771234;
      @(negedge clk);
      fill_valid = 1'b0;
      req_valid  = 1'b0;
      check_rsp("R12 old contents seen", 1'b0, 1'b0, '0);
      lookup("R12 entry present after", 32'h77779999, 1'b1, 1'b0, 20'hABCDE);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule